// File: doc/BRIEF.md
# Programmable Raster Timing Controller

This block produces every timing signal a character-cell display needs. It runs from a clock that ticks once per character cell. A character position counter runs across each scanline, and a scanline counter runs down each character row. A row counter steps through the frame. From these counters the block derives horizontal and vertical sync pulses, a display-enable (blanking) signal, a 14-bit linear address into display memory, and a 4-bit scanline index for a character generator. It also drives a cursor output, which can blink.

A processor programs the block through a small two-port register interface. The select port picks a register and the data port reads or writes the register it picks. The block leaves reset set for 80 characters by 24 rows with 12 scanlines per row. The processor can reshape the raster at any time, and the counters wrap at the new limits on their next pass.

Top module: `crt_raster_timer`

## Requirements
- R1: A write to the index port (`sel`=0) stores `wdata[4:0]` as the selected register number. A read of the index port returns that number in bits 4:0, with bits 7:5 at zero.
- R2: A data-port access (`sel`=1) reads or writes the selected register. The map is:
  - 0: line total minus one (8 bits).
  - 1: displayed characters (8 bits).
  - 2: hsync start column (8 bits).
  - 3: sync widths, with the hsync width in characters at [3:0] and the vsync width in scanlines at [7:4].
  - 4: frame rows minus one (7 bits).
  - 5: displayed rows (7 bits).
  - 6: vsync row (7 bits).
  - 7: scanlines per row minus one (4 bits).
  - 8: cursor mode (bits 1:0).
  - 9 and 10: start address, high 6 bits and low 8 bits.
  - 11 and 12: cursor address, high 6 bits and low 8 bits.
  
  Bits beyond each field's width read as zero.
- R3: A scanline lasts (reg 0)+1 character clocks. `hsync` is high for (reg 3[3:0]) clocks, starting at column (reg 2). A width of 0 gives no pulse.
- R4: `ma` equals the current row's start address plus the character column, so it rises by one on every character clock within a scanline. The row start equals the start address in the top row of a frame. It grows by the displayed character count after each complete character row.
- R5: `ra` counts scanlines within a character row from 0 to (reg 7). It steps at the end of each scanline and returns to 0 after (reg 7).
- R6: A frame holds (reg 4)+1 character rows. `vsync` is high for (reg 3[7:4]) scanlines, starting at scanline 0 of row (reg 6).
- R7: `de` is high only while the column is below (reg 1) and the row is below (reg 5). It is low during both horizontal and vertical blanking.
- R8: `cursor` is high when `de` is high, `ma` equals the cursor address, and the mode allows it. The mode field takes these values:
  - 0: steady.
  - 1: off.
  - 2: blinks, shown for 16 frames and then hidden for 16.
  - 3: blinks, shown for 32 frames and then hidden for 32.
  
  The frame count is zero after reset, so a blinking cursor starts in its shown phase.
- R9: After reset the registers hold 99, 80, 84, 0x28, 26, 24, 25, 11, 0, 0, 0, 0, 0. All counters are zero.
- R10: Register numbers 13 to 31 select no storage. Data writes to them change nothing, and data reads from them return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs | input | 1 | Register access strobe |
| we | input | 1 | Write when high, read when low |
| sel | input | 1 | 0 selects the index port, 1 selects the data port |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, zero when `cs` is low |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Display enable |
| ma | output | 14 | Linear display memory address |
| ra | output | 4 | Scanline within the character row |
| cursor | output | 1 | Cursor video |

## Verification
The hardest states to reach are the blink phases of the cursor. They change only after 16 or 32 whole frames, and the row-start accumulation must also wrap correctly at the frame boundary. At the default format those frame counts would need about a million clocks. The stimulus therefore reprograms a tiny raster of 10 columns, 3 scanlines and 5 rows, so that each frame lasts 150 clocks. It then runs each blink mode across both of its phases, while a reference model in the bench follows the same register writes and compares every output on every clock.

// File: rtl/crt_raster_pkg.sv
package crt_raster_pkg;

  localparam int MA_W   = 14;
  localparam int RA_W   = 4;
  localparam int HC_W   = 8;
  localparam int ROW_W  = 7;
  localparam int IDX_W  = 5;
  localparam int NIMPL  = 13;
  localparam int FC_W   = 6;
  localparam int LINE_W = 12;

  typedef struct packed {
    logic [HC_W-1:0]  htot;
    logic [HC_W-1:0]  hdisp;
    logic [HC_W-1:0]  hpos;
    logic [3:0]       hw;
    logic [3:0]       vw;
    logic [ROW_W-1:0] vtot;
    logic [ROW_W-1:0] vdisp;
    logic [ROW_W-1:0] vpos;
    logic [RA_W-1:0]  maxs;
    logic [1:0]       cmode;
    logic [MA_W-1:0]  start;
    logic [MA_W-1:0]  cur;
  } crt_cfg_t;

  function automatic logic [7:0] reg_default(input int i);
    case (i)
      0: return 8'd99;
      1: return 8'd80;
      2: return 8'd84;
      3: return 8'h28;
      4: return 8'd26;
      5: return 8'd24;
      6: return 8'd25;
      7: return 8'd11;
      default: return 8'd0;
    endcase
  endfunction

  function automatic logic [7:0] reg_mask(input int i);
    case (i)
      4, 5, 6: return 8'h7F;
      7:       return 8'h0F;
      8:       return 8'h03;
      9, 11:   return 8'h3F;
      default: return 8'hFF;
    endcase
  endfunction

  // High while cnt lies in [pos, pos+width)
  function automatic logic in_window(input logic [LINE_W-1:0] cnt,
                                     input logic [LINE_W-1:0] pos,
                                     input logic [3:0] width);
    logic [LINE_W-1:0] d;
    d = cnt - pos;
    return (cnt >= pos) && (d < {{(LINE_W-4){1'b0}}, width});
  endfunction

  // Scanline number counted from the top of the frame
  function automatic logic [LINE_W-1:0] frame_line(input logic [ROW_W-1:0] row,
                                                   input logic [RA_W-1:0] maxs,
                                                   input logic [RA_W-1:0] sl);
    logic [LINE_W-1:0] per_row;
    per_row = {{(LINE_W-RA_W){1'b0}}, maxs} + 1'b1;
    return {{(LINE_W-ROW_W){1'b0}}, row} * per_row + {{(LINE_W-RA_W){1'b0}}, sl};
  endfunction

  function automatic logic cursor_phase(input logic [1:0] mode, input logic [FC_W-1:0] fc);
    case (mode)
      2'd0: return 1'b1;
      2'd2: return ~fc[4];
      2'd3: return ~fc[5];
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/crt_regbank.sv
module crt_regbank
  import crt_raster_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs,
  input  logic       we,
  input  logic       sel,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output crt_cfg_t   cfg
);
  logic [IDX_W-1:0] idx;
  logic [7:0]       regs [NIMPL];
  logic             wr_idx, wr_dat;

  assign wr_idx = cs && we && !sel;
  assign wr_dat = cs && we && sel;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      idx <= '0;
    else if (wr_idx) idx <= wdata[IDX_W-1:0];

  for (genvar i = 0; i < NIMPL; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                             regs[i] <= reg_default(i);
      else if (wr_dat && idx == IDX_W'(i))    regs[i] <= wdata & reg_mask(i);
  end

  always_comb begin
    rdata = '0;
    if (cs) begin
      if (!sel) rdata = {{(8-IDX_W){1'b0}}, idx};
      else
        for (int i = 0; i < NIMPL; i++)
          if (idx == IDX_W'(i)) rdata = regs[i];
    end
  end

  always_comb begin
    cfg.htot  = regs[0];
    cfg.hdisp = regs[1];
    cfg.hpos  = regs[2];
    cfg.hw    = regs[3][3:0];
    cfg.vw    = regs[3][7:4];
    cfg.vtot  = regs[4][ROW_W-1:0];
    cfg.vdisp = regs[5][ROW_W-1:0];
    cfg.vpos  = regs[6][ROW_W-1:0];
    cfg.maxs  = regs[7][RA_W-1:0];
    cfg.cmode = regs[8][1:0];
    cfg.start = {regs[9][MA_W-9:0], regs[10]};
    cfg.cur   = {regs[11][MA_W-9:0], regs[12]};
  end
endmodule

// File: rtl/crt_hscan.sv
module crt_hscan
  import crt_raster_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  crt_cfg_t        cfg,
  output logic [HC_W-1:0] hcnt,
  output logic            line_end,
  output logic            hsync,
  output logic            hde
);
  assign line_end = (hcnt >= cfg.htot);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        hcnt <= '0;
    else if (line_end) hcnt <= '0;
    else               hcnt <= hcnt + 1'b1;

  assign hsync = in_window(LINE_W'(hcnt), LINE_W'(cfg.hpos), cfg.hw);
  assign hde   = (hcnt < cfg.hdisp);
endmodule

// File: rtl/crt_vscan.sv
module crt_vscan
  import crt_raster_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  crt_cfg_t         cfg,
  input  logic             line_end,
  output logic [RA_W-1:0]  ra,
  output logic [MA_W-1:0]  row_start,
  output logic [FC_W-1:0]  fcnt,
  output logic             row_end,
  output logic             frame_end,
  output logic             vsync,
  output logic             vde
);
  logic [ROW_W-1:0] row;

  assign row_end   = line_end && (ra >= cfg.maxs);
  assign frame_end = row_end && (row >= cfg.vtot);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ra        <= '0;
      row       <= '0;
      row_start <= '0;
      fcnt      <= '0;
    end else if (frame_end) begin
      ra        <= '0;
      row       <= '0;
      row_start <= cfg.start;
      fcnt      <= fcnt + 1'b1;
    end else if (row_end) begin
      ra        <= '0;
      row       <= row + 1'b1;
      row_start <= row_start + MA_W'(cfg.hdisp);
    end else if (line_end) begin
      ra        <= ra + 1'b1;
    end

  assign vsync = in_window(frame_line(row, cfg.maxs, ra),
                           frame_line(cfg.vpos, cfg.maxs, '0), cfg.vw);
  assign vde   = (row < cfg.vdisp);
endmodule

// File: rtl/crt_raster_timer.sv
module crt_raster_timer
  import crt_raster_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cs,
  input  logic        we,
  input  logic        sel,
  input  logic [7:0]  wdata,
  output logic [7:0]  rdata,
  output logic        hsync,
  output logic        vsync,
  output logic        de,
  output logic [13:0] ma,
  output logic [3:0]  ra,
  output logic        cursor
);
  crt_cfg_t         cfg;
  logic [HC_W-1:0]  hcnt;
  logic             line_end, row_end, frame_end, hde, vde;
  logic [MA_W-1:0]  row_start, cur_addr;
  logic [FC_W-1:0]  fcnt;

  crt_regbank u_regs (.clk, .rst_n, .cs, .we, .sel, .wdata, .rdata, .cfg);

  crt_hscan u_h (.clk, .rst_n, .cfg, .hcnt, .line_end, .hsync, .hde);

  crt_vscan u_v (.clk, .rst_n, .cfg, .line_end, .ra, .row_start, .fcnt,
                 .row_end, .frame_end, .vsync, .vde);

  assign cur_addr = cfg.cur;
  assign ma       = row_start + MA_W'(hcnt);
  assign de       = hde && vde;
  assign cursor   = de && (ma == cur_addr) && cursor_phase(cfg.cmode, fcnt);
endmodule

// File: rtl/crt_raster_checker.sv
module crt_raster_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  hcnt,
  input logic        line_end,
  input logic        row_end,
  input logic [13:0] ma,
  input logic [3:0]  ra,
  input logic        de,
  input logic        cursor,
  input logic [13:0] cur_addr
);
  a_r3_col_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    line_end |=> hcnt == 8'd0);

  a_r4_ma_step: assert property (@(posedge clk) disable iff (!rst_n)
    !line_end |=> ma == $past(ma) + 14'd1);

  a_r5_ra_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !line_end |=> $stable(ra));

  a_r5_ra_step: assert property (@(posedge clk) disable iff (!rst_n)
    (line_end && !row_end) |=> ra == $past(ra) + 4'd1);

  a_r5_ra_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    row_end |=> ra == 4'd0);

  a_r8_cursor_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    cursor |-> (de && ma == cur_addr));
endmodule

bind crt_raster_timer crt_raster_checker u_chk (
  .clk(clk), .rst_n(rst_n), .hcnt(hcnt), .line_end(line_end),
  .row_end(row_end), .ma(ma), .ra(ra), .de(de), .cursor(cursor),
  .cur_addr(cur_addr)
);

// File: tb/crt_raster_timer_tb.sv
module crt_raster_timer_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cs = 1'b0, we = 1'b0, sel = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic hsync, vsync, de, cursor;
  logic [13:0] ma;
  logic [3:0] ra;

  int ntest = 0, nfail = 0;
  bit cmp_on = 1'b0;
  int cur_seen = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  crt_raster_timer dut_i (.clk, .rst_n, .cs, .we, .sel, .wdata, .rdata,
                          .hsync, .vsync, .de, .ma, .ra, .cursor);

  // ---------------- reference model ----------------
  int s_reg [13];
  int s_idx;
  int m_hc, m_ra, m_row, m_rs, m_fc;

  function automatic int mask_of(int i);
    if (i >= 4 && i <= 6) return 'h7F;
    if (i == 7) return 'h0F;
    if (i == 8) return 'h03;
    if (i == 9 || i == 11) return 'h3F;
    return 'hFF;
  endfunction

  function automatic void model_reset();
    int dflt [13] = '{99, 80, 84, 'h28, 26, 24, 25, 11, 0, 0, 0, 0, 0};
    for (int i = 0; i < 13; i++) s_reg[i] = dflt[i];
    s_idx = 0; m_hc = 0; m_ra = 0; m_row = 0; m_rs = 0; m_fc = 0;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) model_reset();
    else begin
      if (m_hc >= s_reg[0]) begin
        m_hc = 0;
        if (m_ra >= s_reg[7]) begin
          m_ra = 0;
          if (m_row >= s_reg[4]) begin
            m_row = 0;
            m_rs = (s_reg[9] << 8) | s_reg[10];
            m_fc = (m_fc + 1) % 64;
          end else begin
            m_row++;
            m_rs = (m_rs + s_reg[1]) % 16384;
          end
        end else m_ra++;
      end else m_hc++;
      if (cs && we && !sel) s_idx = wdata & 'h1F;
      if (cs && we && sel && s_idx < 13) s_reg[s_idx] = wdata & mask_of(s_idx);
    end
  end

  function automatic bit win(int c, int p, int w);
    return (c >= p) && (c < p + w);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    ntest++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (cmp_on) begin
    int lines, e_ma, mode;
    bit e_de, e_hs, e_vs, show, e_cur;
    lines = s_reg[7] + 1;
    e_ma = (m_rs + m_hc) % 16384;
    e_de = (m_hc < s_reg[1]) && (m_row < s_reg[5]);
    e_hs = win(m_hc, s_reg[2], s_reg[3] & 15);
    e_vs = win(m_row * lines + m_ra, s_reg[6] * lines, s_reg[3] >> 4);
    mode = s_reg[8];
    show = (mode == 0) || (mode == 2 && ((m_fc >> 4) & 1) == 0) ||
           (mode == 3 && ((m_fc >> 5) & 1) == 0);
    e_cur = e_de && show && (e_ma == ((s_reg[11] << 8) | s_reg[12]));
    chk(hsync == e_hs, "R3 hsync", int'(hsync), int'(e_hs));
    chk(ma == e_ma, "R4 ma", int'(ma), e_ma);
    chk(ra == m_ra, "R5 ra", int'(ra), m_ra);
    chk(vsync == e_vs, "R6 vsync", int'(vsync), int'(e_vs));
    chk(de == e_de, "R7 de", int'(de), int'(e_de));
    chk(cursor == e_cur, "R8 cursor", int'(cursor), int'(e_cur));
    if (cursor) cur_seen++;
  end

  // ---------------- bus tasks ----------------
  task automatic wr(input bit s, input int d);
    @(negedge clk); cs = 1; we = 1; sel = s; wdata = 8'(d);
    @(negedge clk); cs = 0; we = 0;
  endtask

  task automatic wreg(input int i, input int d);
    wr(0, i); wr(1, d);
  endtask

  task automatic rreg(input int i, output int v);
    wr(0, i);
    @(negedge clk); cs = 1; we = 0; sel = 1; #1 v = rdata; cs = 0;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    int dflt [13] = '{99, 80, 84, 'h28, 26, 24, 25, 11, 0, 0, 0, 0, 0};
    int v;
    rst_n = 0; run(3); rst_n = 1; #1;
    chk(ma == 0, "R9 ma after reset", int'(ma), 0);
    chk(ra == 0, "R9 ra after reset", int'(ra), 0);
    chk(de == 1, "R9 de after reset", int'(de), 1);
    chk(hsync == 0 && vsync == 0, "R9 syncs after reset", int'({hsync, vsync}), 0);
    chk(cursor == 1, "R9 cursor at address 0", int'(cursor), 1);
    cmp_on = 1;
    for (int i = 0; i < 13; i++) begin
      rreg(i, v);
      chk(v == dflt[i], "R9 register default", v, dflt[i]);
    end
  endtask

  task automatic t_regs();
    int v;
    wr(0, 'hE7);
    @(negedge clk); cs = 1; we = 0; sel = 0; #1 v = rdata; cs = 0;
    chk(v == 7, "R1 index readback", v, 7);
    wreg(11, 'hFF); rreg(11, v);
    chk(v == 'h3F, "R2 masked high cursor byte", v, 'h3F);
    wreg(7, 'hF3); rreg(7, v);
    chk(v == 3, "R2 masked scanline field", v, 3);
    wreg(11, 0); wreg(7, 11);
    wreg(20, 'h55); rreg(20, v);
    chk(v == 0, "R10 index 20 reads zero", v, 0);
    wreg(13, 'hAA); rreg(13, v);
    chk(v == 0, "R10 index 13 reads zero", v, 0);
    rreg(0, v);
    chk(v == 99, "R10 line total untouched", v, 99);
    rreg(12, v);
    chk(v == 0, "R10 cursor low untouched", v, 0);
  endtask

  task automatic t_default_lines();
    run(2600);  // two full character rows at 80x24x12
    chk(cycles > 2600, "R4 default rows ran", cycles, 2600);
  endtask

  task automatic t_small_frame();
    wreg(0, 9); wreg(1, 6); wreg(2, 7); wreg(3, 'h12);
    wreg(4, 4); wreg(5, 3); wreg(6, 4); wreg(7, 2);
    wreg(9, 0); wreg(10, 2); wreg(11, 0); wreg(12, 9);
    cur_seen = 0;
    run(150 * 6);
    chk(cur_seen > 0, "R8 steady cursor seen", cur_seen, 1);
    wreg(8, 1); cur_seen = 0;
    run(150 * 2);
    chk(cur_seen == 0, "R8 mode off hides cursor", cur_seen, 0);
  endtask

  task automatic t_blink(input int mode, input int frames);
    int seen_start;
    wreg(8, mode); cur_seen = 0;
    run(150 * frames);
    seen_start = cur_seen;
    chk(seen_start > 0, mode == 2 ? "R8 blink16 visible" : "R8 blink32 visible", seen_start, 1);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nfail++; ntest++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", ntest, nfail);
    $finish;
  end

  initial begin
    t_reset();
    t_regs();
    t_default_lines();
    t_small_frame();
    t_blink(2, 36);
    t_blink(3, 70);
    $display("[TB] %0d tests run, %0d failed", ntest, nfail);
    $finish;
  end
endmodule